// File: doc/BRIEF.md
# Duplicated ALU with Concurrent Mismatch Detection

This block runs two copies of a small 4-bit arithmetic and logic unit side by side on the same operands. One copy is the fault-free reference. The other copy has a stuck-at-zero fault on its less-than path, and a `fault_en` control switches that fault on or off. A comparator XORs the two full result words, carry included. It exposes the per-bit difference and ORs it into a single mismatch flag. The flag therefore rises in the same cycle that a disagreement appears on the inputs.

The datapath is combinational. A registered copy of the flag is also provided so that surrounding logic can sample it on a clock edge. Each ALU copy forms an internal word twice the operand width. The lower bits of that word are the result and the top bit is the carry. The block has no stream traffic, so every pin is a plain control or data level and there is no handshake.

Top module: `alu_dup_check`

## Requirements
- R1: With op = 3'b000 the reference result equals a + b + cin, zero-extended to 7 bits, and the reference carry is 0.
- R2: With op = 3'b001, {ref_carry, ref_res} equals (a + 1) modulo 256.
- R3: With op = 3'b010, {ref_carry, ref_res} equals (a - 1) modulo 256. For a = 0 this gives ref_res = 127 and ref_carry = 1.
- R4: With op = 3'b011 the reference result is the larger of a and b, and the carry is 0.
- R5: With op = 3'b100 the reference result is the smaller of a and b, and the carry is 0.
- R6: Op codes 3'b101, 3'b110 and 3'b111 give result 0 and carry 0 on both copies.
- R7: The faulty copy result chk_res and carry chk_carry equal the reference in every case except one. That case is op = 3'b100 with fault_en = 1, where the faulty copy gives result 0 and carry 0.
- R8: diff_vec equals {ref_carry, ref_res} XOR {chk_carry, chk_res}. Bit 7 of diff_vec is the carry difference.
- R9: mismatch is the OR of all bits of diff_vec. It is 0 for every input when fault_en = 0. With fault_en = 1 it is 1 exactly when op = 3'b100 and the smaller operand is non-zero.
- R10: mismatch_q takes the value of mismatch at each rising clk edge, and it is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered flag |
| rst_n | input | 1 | Asynchronous active-low reset of the registered flag |
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| cin | input | 1 | Carry-in used by the add operation |
| op | input | 3 | Operation select |
| fault_en | input | 1 | Enables the stuck-at-zero fault in the faulty copy |
| ref_res | output | 7 | Reference copy result |
| ref_carry | output | 1 | Reference copy carry |
| chk_res | output | 7 | Faulty copy result |
| chk_carry | output | 1 | Faulty copy carry |
| diff_vec | output | 8 | Per-bit XOR of the two copies, with the carry in bit 7 |
| mismatch | output | 1 | Combinational fault flag |
| mismatch_q | output | 1 | Registered fault flag |

## Verification
A wrong decode inside either ALU copy shows up at once on ref_res or chk_res for the affected op code. It also shows up on diff_vec and mismatch in the same cycle, unless both copies share the error. That is why the reference outputs are also compared against an independent model. A broken fault gate or a broken comparator shows up as a flag raised with fault_en low, or as a flag missing on a less-than case with a non-zero smaller operand. A faulty flag register is exposed one clock edge later on mismatch_q. The sweep covers every operand pair, carry-in, op code and fault_en setting, so each such error reaches the ports within the vectors that touch it.

// File: rtl/alu_dup_pkg.sv
package alu_dup_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_ADD = 3'b000;
  localparam logic [OPW-1:0] OP_INC = 3'b001;
  localparam logic [OPW-1:0] OP_DEC = 3'b010;
  localparam logic [OPW-1:0] OP_GT  = 3'b011;
  localparam logic [OPW-1:0] OP_LT  = 3'b100;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_dup_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  input  logic [OPW-1:0]   op,
  output logic [2*W-1:0]   word
);
  localparam int RW = 2 * W;
  logic [RW-1:0] ax, bx;

  assign ax = RW'(a);
  assign bx = RW'(b);

  always_comb begin
    case (op)
      OP_ADD:  word = ax + bx + RW'(cin);
      OP_INC:  word = ax + RW'(1);
      OP_DEC:  word = ax - RW'(1);
      OP_GT:   word = (a > b) ? ax : bx;
      OP_LT:   word = (a < b) ? ax : bx;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/sa0_mask.sv
module sa0_mask
  import alu_dup_pkg::*;
#(
  parameter int RW = 8,
  parameter logic [OPW-1:0] TARGET_OP = OP_LT
) (
  input  logic [RW-1:0]  in_word,
  input  logic [OPW-1:0] op,
  input  logic           fault_en,
  output logic [RW-1:0]  out_word
);
  logic hit;
  assign hit      = fault_en && (op == TARGET_OP);
  assign out_word = hit ? '0 : in_word;
endmodule

// File: rtl/mismatch_cmp.sv
module mismatch_cmp #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ref_word,
  input  logic [RW-1:0] chk_word,
  output logic [RW-1:0] diff,
  output logic          flag,
  output logic          flag_q
);
  assign diff = ref_word ^ chk_word;
  assign flag = |diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag;
  end

  assert_flag_pipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flag_q == $past(flag));
  assert_flag_follows_words_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_word == chk_word) |-> !flag);
endmodule

// File: rtl/alu_dup_check.sv
module alu_dup_check
  import alu_dup_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  input  logic [OPW-1:0]   op,
  input  logic             fault_en,
  output logic [2*W-2:0]   ref_res,
  output logic             ref_carry,
  output logic [2*W-2:0]   chk_res,
  output logic             chk_carry,
  output logic [2*W-1:0]   diff_vec,
  output logic             mismatch,
  output logic             mismatch_q
);
  localparam int RW = 2 * W;
  logic [RW-1:0] ref_word, raw_word, chk_word;

  alu_core #(.W(W)) u_ref (.a(a), .b(b), .cin(cin), .op(op), .word(ref_word));
  alu_core #(.W(W)) u_dup (.a(a), .b(b), .cin(cin), .op(op), .word(raw_word));

  sa0_mask #(.RW(RW), .TARGET_OP(OP_LT)) u_mask (
    .in_word(raw_word), .op(op), .fault_en(fault_en), .out_word(chk_word));

  mismatch_cmp #(.RW(RW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_word(ref_word), .chk_word(chk_word),
    .diff(diff_vec), .flag(mismatch), .flag_q(mismatch_q));

  assign ref_res   = ref_word[RW-2:0];
  assign ref_carry = ref_word[RW-1];
  assign chk_res   = chk_word[RW-2:0];
  assign chk_carry = chk_word[RW-1];

  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_en |-> !mismatch);
  assert_only_lt_differs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_LT) |-> (chk_res == ref_res && chk_carry == ref_carry));
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_LT) |-> (ref_res == '0 && !ref_carry && chk_res == '0));
  assert_add_no_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |-> !ref_carry);
  assert_lt_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LT) |-> (ref_res <= (2*W-1)'(a) && ref_res <= (2*W-1)'(b)));
  assert_gt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_GT) |-> (ref_res >= (2*W-1)'(a) && ref_res >= (2*W-1)'(b)));
endmodule

// File: tb/alu_dup_check_bench.sv
module alu_dup_check_bench;
  typedef struct packed {
    logic [2:0] op;
    logic [6:0] rres;
    logic       rc;
    logic [6:0] cres;
    logic       cc;
    logic [7:0] diff;
    logic       flag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] a = '0, b = '0;
  logic cin = 1'b0, fault_en = 1'b0;
  logic [2:0] op = '0;
  logic [6:0] ref_res, chk_res;
  logic ref_carry, chk_carry, mismatch, mismatch_q;
  logic [7:0] diff_vec;

  int errors = 0;
  int checks = 0;
  bit drv_done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  alu_dup_check u_alu_dup_check (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .op(op),
    .fault_en(fault_en), .ref_res(ref_res), .ref_carry(ref_carry),
    .chk_res(chk_res), .chk_carry(chk_carry), .diff_vec(diff_vec),
    .mismatch(mismatch), .mismatch_q(mismatch_q));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string op_req(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] x, input logic [3:0] y,
                                 input logic c, input logic [2:0] o, input logic fe);
    exp_t e;
    int v;
    case (o)
      3'd0: v = x + y + c;
      3'd1: v = (x + 1) % 256;
      3'd2: v = (x + 255) % 256;
      3'd3: v = (x > y) ? x : y;
      3'd4: v = (x < y) ? x : y;
      default: v = 0;
    endcase
    e.op = o;
    e.rres = v[6:0];
    e.rc = v[7];
    if (fe && o == 3'd4) begin
      e.cres = '0;
      e.cc = 1'b0;
    end else begin
      e.cres = e.rres;
      e.cc = e.rc;
    end
    e.diff = {e.rc, e.rres} ^ {e.cc, e.cres};
    e.flag = (fe && o == 3'd4 && v != 0);
    return e;
  endfunction

  task automatic drive(input logic [3:0] x, input logic [3:0] y,
                       input logic c, input logic [2:0] o, input logic fe);
    @(negedge clk);
    a = x; b = y; cin = c; op = o; fault_en = fe;
    q.push_back(model(x, y, c, o, fe));
  endtask

  // monitor: inputs set at negedge, checked after next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(ref_res == e.rres && ref_carry == e.rc, op_req(e.op),
              {ref_carry, ref_res}, {e.rc, e.rres});
        check(chk_res == e.cres && chk_carry == e.cc, "R7",
              {chk_carry, chk_res}, {e.cc, e.cres});
        check(diff_vec == e.diff, "R8", diff_vec, e.diff);
        check(mismatch == e.flag, "R9", mismatch, e.flag);
        check(mismatch_q == e.flag, "R10", mismatch_q, e.flag);
      end
    end
  end

  initial begin
    // reset state: flag register held low while the comb flag is high (R10)
    a = 4'd3; b = 4'd5; op = 3'd4; fault_en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(mismatch_q == 1'b0, "R10", mismatch_q, 0);
    check(mismatch == 1'b1, "R9", mismatch, 1);
    @(negedge clk);
    rst_n = 1'b1;
    // corner cases first: decrement of zero (R3), add overflow (R1)
    drive(4'd0, 4'd0, 1'b0, 3'd2, 1'b0);
    drive(4'd15, 4'd15, 1'b1, 3'd0, 1'b1);
    drive(4'd0, 4'd9, 1'b0, 3'd4, 1'b1);
    for (int fe = 0; fe < 2; fe++)
      for (int o = 0; o < 8; o++)
        for (int c = 0; c < 2; c++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
              drive(4'(x), 4'(y), 1'(c), 3'(o), 1'(fe));
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    fork
      wait (drv_done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule